// File: doc/BRIEF.md
# Serial Sensitivity Configuration Loader

This block receives a six-bit configuration word over a three-wire serial link made of an active-low chip select, a serial clock and a data line. The word carries two things. The top five bits are a bandpass gain code, where each step is 1 dB and the legal range runs from 0 to 27 dB. The lowest bit picks the line-signalling frequency, with 1 meaning 12 kHz and 0 meaning 16 kHz. All three serial pins are sampled by the system clock through two-flop synchronisers, and their edges are found inside the block. A word takes effect only when chip select returns high after exactly six rising serial-clock edges. Any frame with a different edge count leaves the stored configuration untouched.

A preset pin chooses between two modes. When the pin is high the block is in fixed mode: the serial pins have no effect, the frequency comes straight from a dedicated system pin, and the gain output is forced to zero. When the preset pin is low the block is in controlled mode: the serially loaded word drives the outputs and the system pin is ignored. A received gain code in the reserved range 28 to 31 is replaced by 20, and a sticky error flag is set. Each accepted word raises a one-cycle done pulse.

Top module: `sens_cfg_loader`

## Requirements
- R1: After reset, in controlled mode, sys_12k is 1, gain_code is 0, gain_err is 0, and load_done has not pulsed.
- R2: In controlled mode, a frame of exactly six rising sclk edges with cs_n low, closed by cs_n rising, is accepted. The first bit received becomes gain_code[4], the fifth becomes gain_code[0], and the sixth becomes sys_12k (1 = 12 kHz, 0 = 16 kHz).
- R3: A frame with any other number of rising sclk edges (0 to 5, or 7 and more) changes neither output and gives no load_done pulse.
- R4: Data is taken only at rising sclk edges. If sdata changes while sclk is high, the bit already captured is not altered.
- R5: An accepted gain code of 28 to 31 is presented as 20 (binary 10100) and sets gain_err. The frequency bit of that word is still applied.
- R6: Once set, gain_err stays at 1 through later legal loads, until reset.
- R7: In fixed mode (preset_lvl = 1), gain_code is 0 and sys_12k follows sys_pin. Serial frames produce no load_done pulse and leave the stored word unchanged; that stored word reappears when the block returns to controlled mode.
- R8: In controlled mode, sys_pin has no effect on sys_12k.
- R9: load_done is a single-cycle pulse, raised exactly once for each accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, first bit is the gain MSB |
| preset_lvl | input | 1 | 1 = fixed mode, 0 = controlled mode |
| sys_pin | input | 1 | Frequency select used in fixed mode, 1 = 12 kHz |
| sys_12k | output | 1 | Active frequency select, 1 = 12 kHz, 0 = 16 kHz |
| gain_code | output | 5 | Active bandpass gain code in dB steps |
| load_done | output | 1 | One-cycle pulse per accepted word |
| gain_err | output | 1 | Sticky flag: a reserved gain code was received |

## Verification
Frames are sent with random edge counts from zero to eight, so accepted six-edge frames are mixed with short and long ones; this shows whether the edge count is checked exactly, rather than as an upper or lower bound. Random words cover both the legal and the reserved gain range, which tells clamping apart from plain storage. Some frames change the data while sclk is high, which shows whether sampling happens on the wrong edge. The preset and system pins are toggled at random between frames. This shows whether the mode multiplexer and the protection of the stored word behave correctly, and whether the system pin leaks into controlled mode.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned WORD_W     = 6;
  localparam int unsigned GAIN_W     = WORD_W - 1;
  localparam int unsigned FORBID_MIN = 28;
  localparam int unsigned CLAMP_CODE = 20;
  localparam int unsigned SYNC_STG   = 2;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= RST_VAL;
          else        stg_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= RST_VAL;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/scl_frame_rx.sv
module scl_frame_rx #(
  parameter int unsigned WORD_W = scl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sd_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_MAX = WORD_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic              cs_p_q, sclk_p_q, vld_q;
  logic              cs_p_d, sclk_p_d, vld_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shf_q, shf_d;
  logic              cs_fall, cs_rise, sclk_rise;

  assign cs_fall   = cs_p_q & ~cs_s;
  assign cs_rise   = ~cs_p_q & cs_s;
  assign sclk_rise = ~sclk_p_q & sclk_s;

  always_comb begin
    cs_p_d   = cs_s;
    sclk_p_d = sclk_s;
    cnt_d    = cnt_q;
    shf_d    = shf_q;
    vld_d    = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (cs_fall) begin
      cnt_d = '0;
    end else if (!cs_s && sclk_rise) begin
      shf_d = {shf_q[WORD_W-2:0], sd_s};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end else if (cs_rise) begin
      vld_d = (cnt_q == CNT_W'(WORD_W));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p_q   <= 1'b1;
      sclk_p_q <= 1'b0;
      cnt_q    <= '0;
      shf_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      cs_p_q   <= cs_p_d;
      sclk_p_q <= sclk_p_d;
      cnt_q    <= cnt_d;
      shf_q    <= shf_d;
      vld_q    <= vld_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = shf_q;

  // R2
  vld_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> cs_s);

  // R4
  shf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> $stable(shf_q));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/scl_cfg_store.sv
module scl_cfg_store #(
  parameter int unsigned WORD_W     = scl_pkg::WORD_W,
  parameter int unsigned FORBID_MIN = scl_pkg::FORBID_MIN,
  parameter int unsigned CLAMP_CODE = scl_pkg::CLAMP_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed,
  input  logic              sys_pin_s,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              sys_12k,
  output logic [WORD_W-2:0] gain_code,
  output logic              load_done,
  output logic              gain_err
);
  localparam int unsigned GAIN_W = WORD_W - 1;

  logic              sys_q, sys_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [GAIN_W-1:0] rx_gain;
  logic              rx_bad;

  assign rx_gain = word[WORD_W-1:1];
  assign rx_bad  = (rx_gain >= GAIN_W'(FORBID_MIN));

  always_comb begin
    sys_d  = sys_q;
    gain_d = gain_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (word_vld) begin
      sys_d  = word[0];
      gain_d = rx_bad ? GAIN_W'(CLAMP_CODE) : rx_gain;
      err_d  = err_q | rx_bad;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= 1'b1;
      gain_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sys_q  <= sys_d;
      gain_q <= gain_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign sys_12k   = fixed ? sys_pin_s : sys_q;
  assign gain_code = fixed ? '0 : gain_q;
  assign load_done = done_q;
  assign gain_err  = err_q;

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);

  // R3
  store_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(($stable(gain_q)) && $stable(sys_q)) |-> done_q);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  gain_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q < GAIN_W'(FORBID_MIN));

  // R7
  fixed_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed && $past(fixed) && $past(fixed, 2)) |-> !done_q);
endmodule

// File: rtl/sens_cfg_loader.sv
module sens_cfg_loader #(
  parameter int unsigned WORD_W     = scl_pkg::WORD_W,
  parameter int unsigned FORBID_MIN = scl_pkg::FORBID_MIN,
  parameter int unsigned CLAMP_CODE = scl_pkg::CLAMP_CODE,
  parameter int unsigned SYNC_STG   = scl_pkg::SYNC_STG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              preset_lvl,
  input  logic              sys_pin,
  output logic              sys_12k,
  output logic [WORD_W-2:0] gain_code,
  output logic              load_done,
  output logic              gain_err
);
  localparam int unsigned NPIN = 5;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NPIN-1:0] pin_raw, pin_s;
  logic            cs_s, sclk_s, sd_s, fixed_s, sys_pin_s;
  logic            word_vld;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pin_raw = {sys_pin, preset_lvl, sdata, sclk, cs_n};

  scl_sync #(
    .W       (NPIN),
    .STAGES  (SYNC_STG),
    .RST_VAL (5'b1_1001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_raw),
    .q     (pin_s)
  );

  assign cs_s      = pin_s[0];
  assign sclk_s    = pin_s[1];
  assign sd_s      = pin_s[2];
  assign fixed_s   = pin_s[3];
  assign sys_pin_s = pin_s[4];

  scl_frame_rx #(
    .WORD_W (WORD_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (~fixed_s),
    .cs_s     (cs_s),
    .sclk_s   (sclk_s),
    .sd_s     (sd_s),
    .word_vld (word_vld),
    .word     (word)
  );

  scl_cfg_store #(
    .WORD_W     (WORD_W),
    .FORBID_MIN (FORBID_MIN),
    .CLAMP_CODE (CLAMP_CODE)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fixed     (fixed_s),
    .sys_pin_s (sys_pin_s),
    .word_vld  (word_vld),
    .word      (word),
    .sys_12k   (sys_12k),
    .gain_code (gain_code),
    .load_done (load_done),
    .gain_err  (gain_err)
  );

  // R8
  ctrl_ignores_pin_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fixed_s && $past(!fixed_s) && !$past(load_done) && !load_done) |-> $stable(sys_12k));

  // R7
  fixed_gain_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fixed_s |-> (gain_code == '0));
endmodule

// File: tb/sens_cfg_loader_tb.sv
`timescale 1ns/1ps
module sens_cfg_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sclk, sdata, preset_lvl, sys_pin;
  logic       sys_12k, load_done, gain_err;
  logic [4:0] gain_code;

  int n_chk = 0;
  int n_bad = 0;
  int n_load = 0;

  logic       m_sys;
  logic [4:0] m_gain;
  logic       m_err;
  int         m_load;

  always #2 clk = ~clk;

  sens_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .preset_lvl(preset_lvl), .sys_pin(sys_pin), .sys_12k(sys_12k),
    .gain_code(gain_code), .load_done(load_done), .gain_err(gain_err)
  );

  always @(negedge clk) if (rst_n && load_done) n_load++;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] exp_gain(input logic [5:0] w);
    return (w[5:1] >= 5'd28) ? 5'd20 : w[5:1];
  endfunction

  // Sends nbits, first bit = w[5] downward; bits past six repeat w[0].
  task automatic send(input int nbits, input logic [5:0] w, input bit wiggle);
    cs_n = 1'b0;
    wclk(6);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 6) ? w[5-i] : w[0];
      wclk(5);
      sclk = 1'b1;
      wclk(5);
      if (wiggle) sdata = ~sdata;
      wclk(2);
      sclk = 1'b0;
      wclk(4);
    end
    cs_n = 1'b1;
    wclk(10);
    if (!preset_lvl && nbits == 6) begin
      m_sys  = w[0];
      if (w[5:1] >= 5'd28) m_err = 1'b1;
      m_gain = exp_gain(w);
      m_load++;
    end
  endtask

  task automatic check_all(input string tag);
    if (preset_lvl) begin
      chk({tag, " R7 sys"}, sys_12k, sys_pin);
      chk({tag, " R7 gain"}, gain_code, 0);
    end else begin
      chk({tag, " R2 sys"}, sys_12k, m_sys);
      chk({tag, " R2 gain"}, gain_code, m_gain);
    end
    chk({tag, " R6 err"}, gain_err, m_err);
    chk({tag, " R9 loads"}, n_load, m_load);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog R9 got=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd641));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    preset_lvl = 1'b0; sys_pin = 1'b0;
    m_sys = 1'b1; m_gain = 5'd0; m_err = 1'b0; m_load = 0;
    wclk(4);
    rst_n = 1'b1;
    wclk(8);
    // R1 reset state
    chk("R1 sys", sys_12k, 1);
    chk("R1 gain", gain_code, 0);
    chk("R1 err", gain_err, 0);
    chk("R1 loads", n_load, 0);

    // R2 legal word: gain 6, 16 kHz
    send(6, 6'b001100, 1'b0); check_all("R2 d1");
    // R3 short and long frames
    send(5, 6'b110011, 1'b0); check_all("R3 short");
    send(7, 6'b010101, 1'b0); check_all("R3 long");
    send(0, 6'b111111, 1'b0); check_all("R3 empty");
    // R4 data moves while sclk high
    send(6, 6'b101011, 1'b1); check_all("R4 wiggle");
    // R5 reserved code 29 with 12 kHz
    send(6, 6'b111011, 1'b0); check_all("R5 clamp");
    chk("R5 gain20", gain_code, 20);
    // R6 later legal load keeps error
    send(6, 6'b000110, 1'b0); check_all("R6 keep");
    // R8 sys_pin toggles in controlled mode
    sys_pin = ~m_sys; wclk(8); check_all("R8 pin");
    // R7 fixed mode ignores frames
    preset_lvl = 1'b1; sys_pin = 1'b1; wclk(8); check_all("R7 fix1");
    sys_pin = 1'b0; wclk(8); check_all("R7 fix0");
    send(6, 6'b010001, 1'b0); check_all("R7 frame");
    preset_lvl = 1'b0; wclk(8); check_all("R7 back");

    for (int k = 0; k < 220; k++) begin
      int nb;
      logic [5:0] w;
      nb = int'($urandom_range(0, 11));
      if (nb > 8) nb = 6;
      w = 6'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        preset_lvl = ~preset_lvl;
        sys_pin = 1'($urandom);
        wclk(8);
      end
      if ($urandom_range(0, 3) == 0) begin
        sys_pin = 1'($urandom);
        wclk(8);
      end
      send(nb, w, 1'($urandom));
      check_all("rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule